// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. Software programs it through a small byte-wide register file: it picks a conversion clock divider, a channel, a result format and the module enable, then sets a start/busy bit. The sequencer resolves ten bits, most significant first, one bit per conversion clock period (TAD). In each period it drives a trial code to the DAC and, at the end of the period, keeps or drops the trial bit according to the comparator input. One more period loads the result into a high/low register pair. The sequencer then clears the busy bit and raises a completion flag, which can drive an interrupt through a three-level gate.

Software may cancel a conversion by clearing the busy bit or the enable. The partial code is then thrown away and the previous result is kept. After a cancelled or a finished conversion, the sequencer waits a fixed two TAD before it returns to acquiring. A start requested during that window is held and begins as soon as the window closes. The sample-and-hold, the comparator and the DAC lie outside the block.

Top module: `sar_conv_seq`

## Requirements
- R1: Writing address 0 with bit 1 (start/busy) and bit 0 (enable) both set starts a conversion. Bit 1 of address 0 reads 1 while a conversion is running or pending.
- R2: The result is found MSB first. In each TAD the trial bit is added to `dac_code`. It is kept when `cmp_in` is 1 at the end of that TAD. For an input comparator that returns (input >= dac_code), the result equals the input code (0..1023).
- R3: One TAD lasts div+1 clock cycles, where div is address 1 bits 2:0. Bit 1 of address 0 reads 0 exactly 11 TAD after the start write (10 bit periods plus one load period).
- R4: When a conversion completes, the flag at address 4 bit 6 is set. It stays set until software writes 0 to it.
- R5: `irq` is 1 only while the flag, the mask at address 5 bit 6 and both global bits at address 6 bits 7 and 6 are all 1.
- R6: Writing address 0 with bit 1 clear during a conversion cancels it. The result registers and the flag are left unchanged, and bit 1 reads 0.
- R7: After completion or cancellation, a recovery of 2 TAD follows. A start written during recovery is held and runs when the window ends. Written one cycle after the completion or cancellation edge, it completes 13 TAD minus one cycle after its own write.
- R8: Address 0 bit 7 selects the format. When it is 1 (right), address 2 holds result bits 9:8 in its bits 1:0 and address 3 holds bits 7:0. When it is 0 (left), address 2 holds bits 9:2 and address 3 holds bits 1:0 in its bits 7:6, with zeros elsewhere.
- R9: A start written with enable clear does nothing. Clearing the enable during a conversion cancels it as in R6.
- R10: `sample_en` is 1 only while the block is enabled, idle and out of recovery. `chan_sel` follows address 0 bits 4:2.
- R11: After reset, addresses 0 to 6 read 0, and `irq` and `sample_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code to the DAC |
| sample_en | output | 1 | Acquisition active |
| chan_sel | output | 3 | Selected analog channel |
| irq | output | 1 | Gated completion interrupt |

## Verification
The bench builds the block with its default parameters: a 3-bit divider field and a 2-TAD recovery. It then sweeps the divider at run time from 0 to 7. This brings in the one-cycle TAD, where the period tick fires on every edge, as well as longer periods, so every cycle-count check is exercised at several period lengths. The result checks run against random input codes, the endpoints 0 and 1023, and both formats. Chained starts during recovery, cancellation and enable removal are each placed at fixed points inside a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W  = 10;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RHI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLO   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
  localparam logic [ADDR_W-1:0] A_GLOB  = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_LOAD, S_RECOV} seq_state_t;

  // Place a 10-bit code in a 16-bit high:low pair, right or left aligned.
  function automatic logic [2*REG_W-1:0] place_result(input logic [RES_W-1:0] r,
                                                      input logic right);
    return right ? {{(2*REG_W-RES_W){1'b0}}, r} : {r, {(2*REG_W-RES_W){1'b0}}};
  endfunction
endpackage

// File: rtl/sar_tad_timer.sv
module sar_tad_timer #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             step,
  input  logic             cmp,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] value,
  output logic             last
);
  localparam int IDX_W = $clog2(RES_W);

  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial;

  assign trial    = {{(RES_W-1){1'b0}}, 1'b1} << idx_q;
  assign dac_code = active ? (value | trial) : value;
  assign last     = (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      idx_q <= '0;
    end else if (start) begin
      value <= '0;
      idx_q <= IDX_W'(RES_W - 1);
    end else if (step) begin
      if (cmp) value <= value | trial;
      if (!last) idx_q <= idx_q - 1'b1;
    end
  end

  // R2
  sar_one_bit_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $countones(value) <= $countones($past(value)) + 1);
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int RECOV_TADS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       last,
  input  logic       go_set,
  input  logic       go_stop,
  output seq_state_t state,
  output logic       restart,
  output logic       start,
  output logic       step,
  output logic       done,
  output logic       abort,
  output logic       pending
);
  localparam int RC_W = $clog2(RECOV_TADS + 1);

  seq_state_t nxt;
  logic [RC_W-1:0] rcnt_q;
  logic win_end;

  assign win_end = tick && (rcnt_q == RC_W'(RECOV_TADS - 1));
  assign restart = (nxt != state);

  always_comb begin
    nxt = state; start = 1'b0; step = 1'b0; done = 1'b0; abort = 1'b0;
    unique case (state)
      S_IDLE:  if (go_set) begin nxt = S_CONV; start = 1'b1; end
      S_CONV:  if (go_stop) begin nxt = S_RECOV; abort = 1'b1; end
               else if (tick) begin step = 1'b1; if (last) nxt = S_LOAD; end
      S_LOAD:  if (go_stop) begin nxt = S_RECOV; abort = 1'b1; end
               else if (tick) begin nxt = S_RECOV; done = 1'b1; end
      S_RECOV: if (win_end) begin
                 if (go_set || (pending && !go_stop)) begin nxt = S_CONV; start = 1'b1; end
                 else nxt = S_IDLE;
               end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rcnt_q  <= '0;
      pending <= 1'b0;
    end else begin
      state <= nxt;
      if (state != S_RECOV)  rcnt_q <= '0;
      else if (tick)         rcnt_q <= rcnt_q + 1'b1;
      if (state != S_RECOV || win_end) pending <= 1'b0;
      else if (go_set)                 pending <= 1'b1;
      else if (go_stop)                pending <= 1'b0;
    end
  end

  // R7
  recov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RECOV && !tick) |=> state == S_RECOV);
  // R3
  done_enters_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == S_RECOV && !pending));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int RECOV_TADS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic              sample_en,
  output logic [2:0]        chan_sel,
  output logic              irq
);
  logic             fmt_q, en_q, flag_q, mask_q;
  logic [1:0]       glob_q;
  logic [2:0]       chan_q;
  logic [DIV_W-1:0] div_q;
  logic [RES_W-1:0] res_q, sar_val;
  logic [2*REG_W-1:0] placed;

  logic wr_ctrl, go_set, go_stop;
  logic tick, restart, start, step, done, abort, pending, last;
  seq_state_t state;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign go_set  = wr_ctrl && wdata[1] && wdata[0];
  assign go_stop = wr_ctrl && !(wdata[1] && wdata[0]);

  sar_tad_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(div_q), .tick(tick));

  sar_seq_fsm #(.RECOV_TADS(RECOV_TADS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .last(last), .go_set(go_set),
    .go_stop(go_stop), .state(state), .restart(restart), .start(start),
    .step(step), .done(done), .abort(abort), .pending(pending));

  sar_bit_reg #(.RES_W(RES_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .start(start), .active(state == S_CONV),
    .step(step), .cmp(cmp_in), .dac_code(dac_code), .value(sar_val), .last(last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= 1'b0; en_q <= 1'b0; chan_q <= '0; div_q <= '0;
      flag_q <= 1'b0; mask_q <= 1'b0; glob_q <= '0; res_q <= '0;
    end else begin
      if (wr_ctrl) begin
        fmt_q  <= wdata[7];
        chan_q <= wdata[4:2];
        en_q   <= wdata[0];
      end
      if (wr_en && addr == A_CLK)  div_q  <= wdata[DIV_W-1:0];
      if (wr_en && addr == A_MASK) mask_q <= wdata[6];
      if (wr_en && addr == A_GLOB) glob_q <= wdata[7:6];
      if (done)                          flag_q <= 1'b1;
      else if (wr_en && addr == A_FLAG)  flag_q <= wdata[6];
      if (done) res_q <= sar_val;
    end
  end

  assign placed    = place_result(res_q, fmt_q);
  assign irq       = flag_q && mask_q && glob_q[1] && glob_q[0];
  assign sample_en = en_q && (state == S_IDLE);
  assign chan_sel  = chan_q;

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {fmt_q, 2'b00, chan_q, (state == S_CONV || state == S_LOAD || pending), en_q};
      A_CLK:   rdata = {{(REG_W-DIV_W){1'b0}}, div_q};
      A_RHI:   rdata = placed[2*REG_W-1:REG_W];
      A_RLO:   rdata = placed[REG_W-1:0];
      A_FLAG:  rdata = {1'b0, flag_q, 6'b0};
      A_MASK:  rdata = {1'b0, mask_q, 6'b0};
      A_GLOB:  rdata = {glob_q, 6'b0};
      default: rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[6:5], wdata[REG_W-1:DIV_W]};

  // R6
  abort_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (res_q == $past(res_q) && flag_q == $past(flag_q)));
  // R4
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);
  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (state != S_CONV && state != S_LOAD));
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [9:0] dac_code, vin = '0;
  logic cmp_in, sample_en, irq;
  logic [2:0] chan_sel;
  int checks = 0, failures = 0;
  bit ended = 0;

  always #10 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  sar_conv_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmp_in(cmp_in), .dac_code(dac_code),
    .sample_en(sample_en), .chan_sel(chan_sel), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_done(output int cyc);
    logic [7:0] v;
    cyc = 0; rd(0, v);
    while (v[1]) begin @(negedge clk); cyc++; rd(0, v); end
  endtask

  function automatic int exp_hi(input int v, input bit right);
    return right ? (v / 256) : (v / 4);
  endfunction
  function automatic int exp_lo(input int v, input bit right);
    return right ? (v % 256) : ((v % 4) * 64);
  endfunction

  task automatic check_result(input string tag, input int v, input bit right);
    logic [7:0] h, l;
    rd(2, h); rd(3, l);
    chk({tag, " hi"}, h, exp_hi(v, right));
    chk({tag, " lo"}, l, exp_lo(v, right));
  endtask

  // start a conversion and wait for it; returns measured cycles
  task automatic run_conv(input int v, input bit right, input int div, input logic [2:0] ch,
                          output int cyc);
    wr(1, 8'(div));
    vin = 10'(v);
    wr(0, {right, 2'b00, ch, 2'b11});
    chk("R10 sample_en low while busy", sample_en, 0);
    chk("R10 chan_sel", chan_sel, ch);
    wait_done(cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cyc, seed_dummy, val, dv;
    bit rt;
    seed_dummy = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 7; a++) begin rd(3'(a), v); chk("R11 reg reset", v, 0); end
    chk("R11 irq reset", irq, 0);
    chk("R11 sample_en reset", sample_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 start ignored with enable clear
    wr(0, 8'b0000_0010);
    repeat (5) @(negedge clk);
    rd(0, v); chk("R9 go ignored when disabled", v[1], 0);
    check_result("R9 result untouched", 0, 0);

    // Directed endpoints, both formats
    run_conv(1023, 1'b0, 0, 3'd5, cyc);
    chk("R3 conv cycles div0", cyc, 11);
    check_result("R2 R8 full scale left", 1023, 1'b0);
    rd(4, v); chk("R4 flag set", v[6], 1);
    chk("R5 irq masked", irq, 0);
    repeat (4) @(negedge clk);
    chk("R10 sample_en in idle", sample_en, 1);
    run_conv(0, 1'b1, 7, 3'd2, cyc);
    chk("R3 conv cycles div7", cyc, 88);
    check_result("R2 R8 zero right", 0, 1'b1);
    repeat (20) @(negedge clk);

    // R5 interrupt gating and R4 flag clear
    wr(5, 8'h40); wr(6, 8'hC0);
    chk("R5 irq all gates", irq, 1);
    wr(6, 8'h80); chk("R5 irq peripheral gate off", irq, 0);
    wr(6, 8'h40); chk("R5 irq global gate off", irq, 0);
    wr(6, 8'hC0); chk("R5 irq back on", irq, 1);
    rd(4, v); chk("R4 flag sticky", v[6], 1);
    wr(4, 8'h00);
    rd(4, v); chk("R4 flag cleared", v[6], 0);
    chk("R5 irq after clear", irq, 0);

    // Random conversions
    for (int i = 0; i < 30; i++) begin
      val = int'($urandom_range(1023));
      dv  = int'($urandom_range(7));
      rt  = 1'($urandom_range(1));
      run_conv(val, rt, dv, 3'($urandom_range(7)), cyc);
      chk("R3 conv cycles", cyc, 11 * (dv + 1));
      check_result("R2 R8 random", val, rt);
      rd(0, v); chk("R1 busy clear after done", v[1], 0);
      repeat (2 * (dv + 1) + 1) @(negedge clk);
    end

    // R7 start held during recovery after completion
    run_conv(300, 1'b1, 2, 3'd1, cyc);
    vin = 10'd700;
    wr(0, 8'b1000_0111);
    rd(0, v); chk("R1 R7 pending reads busy", v[1], 1);
    wait_done(cyc);
    chk("R7 held start after done", cyc + 1, 13 * 3 - 1);
    check_result("R7 held start result", 700, 1'b1);
    repeat (8) @(negedge clk);

    // R6 abort by clearing start, then R7 recovery timing
    wr(4, 8'h00);
    vin = 10'd55;
    wr(0, 8'b1000_0011);
    repeat (3) @(negedge clk);
    wr(0, 8'b1000_0001);
    rd(0, v); chk("R6 busy clear on abort", v[1], 0);
    check_result("R6 result kept", 700, 1'b1);
    rd(4, v); chk("R6 no flag on abort", v[6], 0);
    wr(0, 8'b1000_0011);
    wait_done(cyc);
    chk("R7 start after abort", cyc + 1, 13 * 3 - 1);
    check_result("R7 new result", 55, 1'b1);
    repeat (8) @(negedge clk);

    // R9 clearing enable aborts
    wr(4, 8'h00);
    vin = 10'd999;
    wr(0, 8'b0000_0011);
    repeat (6) @(negedge clk);
    wr(0, 8'b0000_0000);
    rd(0, v); chk("R9 disable aborts", v[1], 0);
    check_result("R9 result kept", 55, 1'b0);
    repeat (40) @(negedge clk);
    rd(4, v); chk("R9 no flag", v[6], 0);
    chk("R10 sample_en off when disabled", sample_en, 0);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule